// File: doc/BRIEF.md
# Decimal Carry-Save Reduction Tree

This block takes a set of decimal partial products, each already placed at its digit weight, and reduces them to one radix-10 carry-save number. Each partial product is a vector of BCD digits plus a vector of carry bits, with one carry bit per digit position. The result is a vector of 2N BCD digits and a vector of 2N carry bits. Its numeric value equals the sum of all the inputs. A later carry-propagate stage turns this pair into a plain BCD product.

The reduction uses two cell types. The first is a decimal three-input carry-save row. It adds two digit vectors and one bit vector, and gives one digit vector and one bit vector, with the bit vector shifted up one digit. The second is a carry counter. It adds several carry bits of the same weight into a single decimal digit.

The rows are arranged as a binary tree over the sum vectors. In each pair, the row consumes the carry vector of one member. The carry vectors left over at each level go to two counters, and their digits join the result in two final rows. The result is captured in an output register.

Top module: `dec_cs_tree`

## Requirements
- R1: Every digit of `acc_sum_o` is a BCD value in 0..9. Digit i occupies bits 4i+3..4i.
- R2: Bit 0 of `acc_car_o` is always 0. Bit i of `acc_car_o` has the weight 10^i.
- R3: The numeric value of the output pair (the sum over i of (digit i + carry bit i)·10^i) equals, modulo 10^(2N), the sum over all partial products of their digits and carry bits at the same weights. The two are exactly equal when the true total is below 10^(2N).
- R4: The first level adds the sum vectors of partial products 2k and 2k+1 together with the carry vector of partial product 2k. A digit cell whose three-input total reaches 10 keeps the total minus 10 and sets the carry into the next higher digit. Otherwise it keeps the total and sends no carry.
- R5: The carry vectors of the odd-numbered partial products are counted per digit weight into one digit vector with digits in 0..N/2. That vector is added into the result in the last stage.
- R6: At every later level, the carry vector of the odd member of each pair is not consumed there. All of these vectors are counted per weight into a second digit vector with digits in 0..N/2-1, which is also added in the last stage.
- R7: The outputs are registered. They show the result for the inputs present at the previous rising edge of `clk`. An active-low `rst_n` clears both outputs to zero asynchronously. Inputs held steady give outputs that stay steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| pp_sum_i | input | N*2N*4 | Digit vectors of the N partial products; product p occupies slice [p*8N +: 8N] |
| pp_car_i | input | N*2N | Carry-bit vectors of the N partial products; product p occupies slice [p*2N +: 2N] |
| acc_sum_o | output | 2N*4 | Result digit vector, BCD |
| acc_car_o | output | 2N | Result carry-bit vector, bit i at weight 10^i |

## Verification
The bench builds the tree with N = 4, which gives 8-digit outputs, two levels of pairing rows and a single spare carry vector at the second level. With this small configuration, directed patterns can reach each carry path on its own:
- a cell total of 19 at the first level;
- both odd-product carry bits at the same weight;
- a second-level carry left unconsumed.

In each case the exact output digits are predictable. The same configuration keeps every value within 64-bit arithmetic, so the checks compare the value against a reference:
- modulo 10^8 for random and all-maximum inputs;
- exactly for genuine multiplicand-times-digit partial products.

// File: rtl/dec_tree_pkg.sv
package dec_tree_pkg;

   typedef logic [3:0] bcd_t;

   // Binary total of two digits and a carry bit, at most 19.
   function automatic logic [4:0] raw_total3(input bcd_t a, input bcd_t b, input logic d);
      return {1'b0, a} + {1'b0, b} + {4'b0000, d};
   endfunction

   // Digit that stays in place after the decimal adjustment.
   function automatic bcd_t digit_of3(input bcd_t a, input bcd_t b, input logic d);
      logic [4:0] t;
      logic [4:0] adj;
      t   = raw_total3(a, b, d);
      adj = t - 5'd10;
      return (t >= 5'd10) ? adj[3:0] : t[3:0];
   endfunction

   // Carry into the next higher digit.
   function automatic logic carry_of3(input bcd_t a, input bcd_t b, input logic d);
      return raw_total3(a, b, d) >= 5'd10;
   endfunction

endpackage

// File: rtl/dec_csa_row.sv
module dec_csa_row
   import dec_tree_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W*4-1:0] a_i,
   input  logic [W*4-1:0] b_i,
   input  logic [W-1:0]   d_i,
   output logic [W*4-1:0] s_o,
   output logic [W-1:0]   c_o
);

   if (W < 2) begin : g_bad_w
      $error("dec_csa_row: W must be at least 2");
   end

   assign c_o[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_dig
      assign s_o[i*4 +: 4] = digit_of3(a_i[i*4 +: 4], b_i[i*4 +: 4], d_i[i]);
      if (i < W - 1) begin : g_cy
         assign c_o[i+1] = carry_of3(a_i[i*4 +: 4], b_i[i*4 +: 4], d_i[i]);
      end
   end

endmodule

// File: rtl/dec_carry_counter.sv
module dec_carry_counter #(
   parameter int W = 8,
   parameter int K = 2
) (
   input  logic [K*W-1:0] bits_i,
   output logic [W*4-1:0] z_o
);

   if (K < 1 || K > 9) begin : g_bad_k
      $error("dec_carry_counter: K must lie in 1..9");
   end

   for (genvar j = 0; j < W; j++) begin : g_dig
      logic [3:0] cnt;
      always_comb begin
         cnt = 4'd0;
         for (int k = 0; k < K; k++) begin
            cnt = cnt + {3'b000, bits_i[k*W + j]};
         end
      end
      assign z_o[j*4 +: 4] = cnt;
   end

endmodule

// File: rtl/dec_csa_level.sv
module dec_csa_level #(
   parameter int W = 8,
   parameter int P = 2
) (
   input  logic [2*P*W*4-1:0] s_i,
   input  logic [2*P*W-1:0]   c_i,
   output logic [P*W*4-1:0]   s_o,
   output logic [P*W-1:0]     c_o,
   output logic [P*W-1:0]     sp_o
);

   localparam int DW = W * 4;

   if (P < 1) begin : g_bad_p
      $error("dec_csa_level: P must be at least 1");
   end

   for (genvar p = 0; p < P; p++) begin : g_pair
      dec_csa_row #(.W(W)) u_row (
         .a_i (s_i[(2*p)*DW   +: DW]),
         .b_i (s_i[(2*p+1)*DW +: DW]),
         .d_i (c_i[(2*p)*W    +: W]),
         .s_o (s_o[p*DW +: DW]),
         .c_o (c_o[p*W  +: W])
      );
      assign sp_o[p*W +: W] = c_i[(2*p+1)*W +: W];
   end

endmodule

// File: rtl/dec_cs_tree.sv
module dec_cs_tree #(
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N*2*N*4-1:0]   pp_sum_i,
   input  logic [N*2*N-1:0]     pp_car_i,
   output logic [2*N*4-1:0]     acc_sum_o,
   output logic [2*N-1:0]       acc_car_o
);

   localparam int W     = 2 * N;
   localparam int DW    = W * 4;
   localparam int LOG   = $clog2(N);
   localparam int K_LO  = N / 2;
   localparam int K_HI  = N / 2 - 1;

   if ((N & (N - 1)) != 0 || N < 4 || N > 16) begin : g_bad_n
      $error("dec_cs_tree: N must be a power of two in 4..16");
   end

   logic [K_LO*W-1:0] spare_lo;
   logic [K_HI*W-1:0] spare_hi;

   for (genvar l = 0; l <= LOG; l++) begin : g_lvl
      localparam int CNT = N >> l;
      logic [CNT*DW-1:0] s;
      logic [CNT*W-1:0]  c;
      if (l == 0) begin : g_in
         assign s = pp_sum_i;
         assign c = pp_car_i;
      end else begin : g_red
         logic [CNT*W-1:0] sp;
         dec_csa_level #(.W(W), .P(CNT)) u_lvl (
            .s_i  (g_lvl[l-1].s),
            .c_i  (g_lvl[l-1].c),
            .s_o  (s),
            .c_o  (c),
            .sp_o (sp)
         );
         if (l == 1) begin : g_lo
            assign spare_lo = sp;
         end else begin : g_hi
            localparam int OFF = N / 2 - (N >> (l - 1));
            assign spare_hi[OFF*W +: CNT*W] = sp;
         end
      end
   end

   logic [DW-1:0] cnt_lo;
   logic [DW-1:0] cnt_hi;

   dec_carry_counter #(.W(W), .K(K_LO)) u_cnt_lo (
      .bits_i (spare_lo),
      .z_o    (cnt_lo)
   );

   dec_carry_counter #(.W(W), .K(K_HI)) u_cnt_hi (
      .bits_i (spare_hi),
      .z_o    (cnt_hi)
   );

   logic [DW-1:0] mid_s;
   logic [W-1:0]  mid_c;
   logic [DW-1:0] fin_s;
   logic [W-1:0]  fin_c;

   dec_csa_row #(.W(W)) u_fin_lo (
      .a_i (g_lvl[LOG].s),
      .b_i (cnt_lo),
      .d_i (g_lvl[LOG].c),
      .s_o (mid_s),
      .c_o (mid_c)
   );

   dec_csa_row #(.W(W)) u_fin_hi (
      .a_i (mid_s),
      .b_i (cnt_hi),
      .d_i (mid_c),
      .s_o (fin_s),
      .c_o (fin_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_sum_o <= '0;
         acc_car_o <= '0;
      end else begin
         acc_sum_o <= fin_s;
         acc_car_o <= fin_c;
      end
   end

endmodule

// File: rtl/dec_tree_chk.sv
module dec_tree_chk #(
   parameter int N = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N*2*N*4-1:0]   pp_sum_i,
   input logic [N*2*N-1:0]     pp_car_i,
   input logic [2*N*4-1:0]     acc_sum_o,
   input logic [2*N-1:0]       acc_car_o,
   input logic [2*N*4-1:0]     cnt_lo_i,
   input logic [2*N*4-1:0]     cnt_hi_i
);

   localparam int W = 2 * N;

   function automatic logic digits_within(input logic [W*4-1:0] v, input int lim);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < W; i++) begin
         if (int'(v[i*4 +: 4]) > lim) ok = 1'b0;
      end
      return ok;
   endfunction

   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 2'd0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   // R1
   p_bcd_digits_r1: assert property (@(posedge clk) disable iff (!rst_n)
      digits_within(acc_sum_o, 9));

   // R2
   p_lsb_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_car_o[0] == 1'b0);

   // R5
   p_cnt_lo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      digits_within(cnt_lo_i, N / 2));

   // R6
   p_cnt_hi_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      digits_within(cnt_hi_i, N / 2 - 1));

   // R7
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2) && $past($stable(pp_sum_i) && $stable(pp_car_i))
      |-> ($stable(acc_sum_o) && $stable(acc_car_o)));

endmodule

bind dec_cs_tree dec_tree_chk #(.N(N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pp_sum_i  (pp_sum_i),
   .pp_car_i  (pp_car_i),
   .acc_sum_o (acc_sum_o),
   .acc_car_o (acc_car_o),
   .cnt_lo_i  (cnt_lo),
   .cnt_hi_i  (cnt_hi)
);

// File: tb/tb_dec_cs_tree.sv
module tb_dec_cs_tree;

   localparam int N      = 4;
   localparam int W      = 2 * N;
   localparam int PERIOD = 10;
   localparam longint unsigned MOD = 64'd100000000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N*W*4-1:0]  pp_sum = '0;
   logic [N*W-1:0]    pp_car = '0;
   logic [W*4-1:0]    acc_sum;
   logic [W-1:0]      acc_car;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   dec_cs_tree #(.N(N)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pp_sum_i  (pp_sum),
      .pp_car_i  (pp_car),
      .acc_sum_o (acc_sum),
      .acc_car_o (acc_car)
   );

   function automatic longint unsigned pair_value(input logic [W*4-1:0] s, input logic [W-1:0] c);
      longint unsigned v = 0;
      longint unsigned p = 1;
      for (int i = 0; i < W; i++) begin
         v = v + (longint'(s[i*4 +: 4]) + longint'(c[i])) * p;
         p = p * 10;
      end
      return v % MOD;
   endfunction

   function automatic longint unsigned ref_value();
      longint unsigned v = 0;
      for (int k = 0; k < N; k++) begin
         v = v + pair_value(pp_sum[k*W*4 +: W*4], pp_car[k*W +: W]);
      end
      return v % MOD;
   endfunction

   function automatic logic [W*4-1:0] to_bcd(input longint unsigned v);
      logic [W*4-1:0] r;
      longint unsigned t = v;
      for (int i = 0; i < W; i++) begin
         r[i*4 +: 4] = 4'(t % 10);
         t = t / 10;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      pp_sum = '0;
      pp_car = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_format();
      bit ok = 1'b1;
      for (int i = 0; i < W; i++) if (acc_sum[i*4 +: 4] > 4'd9) ok = 1'b0;
      check(ok, "R1 digits", longint'(acc_sum), 0);
      check(acc_car[0] == 1'b0, "R2 lsb carry", longint'(acc_car), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      pp_sum = {N*W{4'd7}};
      pp_car = {N*W{1'b1}};
      step();
      check(acc_sum == '0 && acc_car == '0, "R7 reset clears",
            {acc_sum, acc_car}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      clear_inputs();
      step();
   endtask

   task automatic t_latency();
      clear_inputs();
      step();
      pp_sum[3*4 +: 4] = 4'd5;
      #1;
      check(acc_sum == '0, "R7 no change before edge", longint'(acc_sum), 0);
      step();
      check(acc_sum == 32'h0000_5000 && acc_car == '0, "R7 one-cycle latency",
            longint'(acc_sum), 64'h5000);
   endtask

   task automatic t_cell_carry();
      clear_inputs();
      pp_sum[0*W*4 + 0 +: 4] = 4'd9;
      pp_sum[1*W*4 + 0 +: 4] = 4'd9;
      pp_car[0*W + 0] = 1'b1;
      step();
      check(acc_sum == 32'h0000_0019 && acc_car == '0, "R4 digit total 19",
            longint'(acc_sum), 64'h19);
      clear_inputs();
      pp_sum[0*W*4 + 8 +: 4] = 4'd4;
      pp_sum[1*W*4 + 8 +: 4] = 4'd5;
      step();
      check(acc_sum == 32'h0000_0900 && acc_car == '0, "R4 digit total 9 no carry",
            longint'(acc_sum), 64'h900);
   endtask

   task automatic t_counter();
      clear_inputs();
      pp_car[1*W + 3] = 1'b1;
      pp_car[3*W + 3] = 1'b1;
      step();
      check(acc_sum == 32'h0000_2000 && acc_car == '0, "R5 odd carries counted",
            longint'(acc_sum), 64'h2000);
   endtask

   task automatic t_spare();
      clear_inputs();
      pp_sum[2*W*4 +: 4] = 4'd9;
      pp_sum[3*W*4 +: 4] = 4'd9;
      pp_car[2*W + 0] = 1'b1;
      step();
      check(acc_sum == 32'h0000_0019 && acc_car == '0, "R6 later-level spare carry",
            longint'(acc_sum), 64'h19);
   endtask

   task automatic t_maximum();
      pp_sum = {N*W{4'd9}};
      pp_car = {N*W{1'b1}};
      step();
      check(pair_value(acc_sum, acc_car) == ref_value(), "R3 all-maximum value",
            pair_value(acc_sum, acc_car), ref_value());
      check_format();
   endtask

   task automatic t_products();
      for (int n = 0; n < 6; n++) begin
         longint unsigned x = 0;
         longint unsigned y = 0;
         longint unsigned sc = 1;
         for (int i = 0; i < N; i++) x = x * 10 + longint'($urandom_range(0, 9));
         clear_inputs();
         for (int i = 0; i < N; i++) begin
            longint unsigned yd = longint'($urandom_range(0, 9));
            y = y + yd * sc;
            pp_sum[i*W*4 +: W*4] = to_bcd(x * yd * sc);
            sc = sc * 10;
         end
         step();
         check(pair_value(acc_sum, acc_car) == x * y, "R3 exact product",
               pair_value(acc_sum, acc_car), x * y);
         check_format();
      end
   endtask

   task automatic t_random();
      for (int n = 0; n < 25; n++) begin
         for (int i = 0; i < N * W; i++) begin
            pp_sum[i*4 +: 4] = 4'($urandom_range(0, 9));
            pp_car[i] = 1'($urandom_range(0, 1));
         end
         step();
         check(pair_value(acc_sum, acc_car) == ref_value(), "R3 random value",
               pair_value(acc_sum, acc_car), ref_value());
         check_format();
      end
   endtask

   task automatic t_hold();
      logic [W*4-1:0] s0;
      logic [W-1:0]   c0;
      step();
      s0 = acc_sum;
      c0 = acc_car;
      step();
      check(acc_sum == s0 && acc_car == c0, "R7 steady inputs",
            longint'(acc_sum), longint'(s0));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_latency();
      t_cell_carry();
      t_counter();
      t_spare();
      t_maximum();
      t_products();
      t_random();
      t_hold();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule